// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a four-wire serial EEPROM model. A fast system clock oversamples the serial clock, the active-low select, the data input and the active-low pause pin. The block shifts in a command byte, an optional 16-bit byte address and any data bytes. It then issues single-cycle requests to the blocks around it: the write-enable latch, the status register and the page-write controller. It also fetches bytes from the storage array while it streams them out on the serial output, which has its own drive enable.

The storage array, the programming timer and the write-protect decision live elsewhere. The array answers a read request with its byte one system clock after the request. The timer reports a busy flag. The status register presents the byte that is shifted out for a status read. Both serial clock polarities that idle low-and-sample-rising and idle-high-and-sample-rising are accepted. The system clock must run at least eight times faster than the serial clock.

Top module: `eeprom_spi_frontend`

## Requirements
- R1: After reset the output enable is low and no request pulse (write enable, write disable, read, page byte, page commit, status commit) is raised.
- R2: The first byte after select falls, MSB first, is a command. The value 0000_x110 raises a one-cycle write-enable pulse and 0000_x100 a one-cycle write-disable pulse, where bit 3 may be either value. At most one request pulse is raised in any cycle.
- R3: A command byte that matches none of 0000_x110, 0000_x100, 0000_x101, 0000_x001, 0000_x011, 0000_x010 makes the block ignore the data input and keep the output disabled until select has risen and fallen again.
- R4: Status read (0000_x101): in the byte slots after the command, the output carries the status input byte MSB first. The status input is taken fresh at the start of each byte slot.
- R5: Array read (0000_x011): after a 16-bit address whose bits above AW are ignored, the output carries the array byte at that address and then at each following address. The address wraps from 2^AW-1 to 0.
- R6: Array write (0000_x010): after the 16-bit address, each complete data byte raises a page-byte pulse with its address and value. Only the low PB address bits advance between bytes, so the address wraps inside its page.
- R7: When select rises on a byte boundary after at least one complete data byte of an array write, a page-commit pulse follows. If select rises in the middle of a byte, no commit is raised.
- R8: Status write (0000_x001): the first data byte is held on the status data output. A status-commit pulse follows the rise of select only on a byte boundary after that byte.
- R9: While the busy input is high, every command other than status read is handled as in R3. Status read still works.
- R10: Taking the pause pin low while the serial clock is low freezes the sequence. While paused, clock edges and data input are ignored and the output is disabled. Raising the pin while the serial clock is low resumes the sequence with no bit lost.
- R11: While select is high the output is disabled. Each rise of select discards any partial command, so the next select period starts with a fresh command byte.
- R12: Both serial clock idle levels (low and high) give the same results. The input is sampled on rising edges and the output changes on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Drive enable for spi_so (low means high impedance) |
| busy | input | 1 | Programming cycle in progress |
| stat_data | input | 8 | Status byte to shift out |
| rd_req | output | 1 | Array read request |
| rd_addr | output | AW | Array read address |
| rd_data | input | 8 | Array byte, valid one clock after rd_req |
| wren_pulse | output | 1 | Set write-enable latch |
| wrdi_pulse | output | 1 | Clear write-enable latch |
| pg_byte_valid | output | 1 | Page data byte received |
| pg_byte_addr | output | AW | Address of that byte |
| pg_byte_data | output | 8 | Value of that byte |
| pg_commit | output | 1 | Start page programming |
| sr_commit | output | 1 | Start status programming |
| sr_data | output | 8 | Byte for the status register |

## Verification
Some rules hold on every cycle, and the bound checker watches them. The output stays disabled while the block is deselected, paused or locked after a rejected command. No more than one request pulse is raised at once. A busy flag blocks the enable and disable pulses. Commits only ever follow a rise of select. Other behaviour can only be shown by the bench's scenarios, which compare against bench models of the array and of page addressing. These include the byte order and content of status and array reads, address wrap at the top of the array and inside a page, and the don't-care command bit and address bits. They also include aborted and misaligned select rises, and a pause in the middle of a byte under both clock idle levels.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_DIN, PH_DOUT, PH_DONE, PH_DEAD
  } phase_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
  } cmd_t;

  // Command byte decode; bit 3 is ignored, upper nibble must be zero.
  function automatic cmd_t op_decode(input logic [7:0] op);
    cmd_t c;
    c = CMD_NONE;
    if (op[7:4] == 4'b0000) begin
      case (op[2:0])
        3'b110:  c = CMD_WREN;
        3'b100:  c = CMD_WRDI;
        3'b101:  c = CMD_RDSR;
        3'b001:  c = CMD_WRSR;
        3'b011:  c = CMD_READ;
        3'b010:  c = CMD_WRITE;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1;
  logic [W-1:0] st2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= INIT;
      st2 <= INIT;
    end else begin
      st1 <= d;
      st2 <= st1;
    end
  end

  assign q = st2;
endmodule

// File: rtl/spi_fe_oshift.sv
module spi_fe_oshift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic [7:0] next_byte,
  output logic       so_bit,
  output logic       byte_start,
  output logic       started
);
  logic [2:0] ocnt;
  logic [6:0] rest;

  assign byte_start = step && (ocnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt    <= '0;
      rest    <= '0;
      so_bit  <= 1'b0;
      started <= 1'b0;
    end else if (clear) begin
      ocnt    <= '0;
      rest    <= '0;
      so_bit  <= 1'b0;
      started <= 1'b0;
    end else if (step) begin
      started <= 1'b1;
      ocnt    <= ocnt + 3'd1;
      if (ocnt == 3'd0) {so_bit, rest} <= next_byte;
      else              {so_bit, rest} <= {rest, 1'b0};
    end
  end
endmodule

// File: rtl/eeprom_spi_frontend.sv
module eeprom_spi_frontend
  import spi_fe_pkg::*;
#(
  parameter int AW = 10,
  parameter int PB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_si,
  input  logic          spi_hold_n,
  output logic          spi_so,
  output logic          spi_so_oe,
  input  logic          busy,
  input  logic [7:0]    stat_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wren_pulse,
  output logic          wrdi_pulse,
  output logic          pg_byte_valid,
  output logic [AW-1:0] pg_byte_addr,
  output logic [7:0]    pg_byte_data,
  output logic          pg_commit,
  output logic          sr_commit,
  output logic [7:0]    sr_data
);
  localparam int SW = (AW - 1 > 7) ? AW - 1 : 7;

  // Address arithmetic kept in functions so the bench can restate it.
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    logic [PB-1:0] lo;
    lo = a[PB-1:0] + 1'b1;
    return {a[AW-1:PB], lo};
  endfunction

  function automatic logic [AW-1:0] read_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [3:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s;

  spi_fe_sync #(.W(4), .INIT(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
    .q(pins_s)
  );
  assign {hold_s, si_s, cs_s, sck_s} = pins_s;

  logic sck_q, cs_q, paused;
  phase_t phase;
  cmd_t   cmd;
  logic [3:0]    cnt;
  logic [SW-1:0] sin;
  logic [AW-1:0] cur_addr;
  logic          rd_wait, byte_seen;
  logic [7:0]    nxt;

  // Named events for the checker.
  logic sel_w, dead_w, sck_rise_evt, sck_fall_evt, cs_fall_evt, cs_rise_evt;
  logic opc_evt;
  logic [7:0]    in_byte;
  logic [AW-1:0] addr_lo;
  cmd_t cmd_dec, cmd_acc;

  assign sel_w        = !cs_s;
  assign dead_w       = (phase == PH_DEAD);
  assign sck_rise_evt = sel_w && !paused && sck_s && !sck_q;
  assign sck_fall_evt = sel_w && !paused && !sck_s && sck_q;
  assign cs_fall_evt  = !cs_s && cs_q;
  assign cs_rise_evt  = cs_s && !cs_q;
  assign in_byte      = {sin[6:0], si_s};
  assign addr_lo      = {sin[AW-2:0], si_s};
  assign opc_evt      = sck_rise_evt && (phase == PH_OPC) && (cnt == 4'd7);
  assign cmd_dec      = op_decode(in_byte);
  assign cmd_acc      = (busy && cmd_dec != CMD_RDSR) ? CMD_NONE : cmd_dec;

  logic so_bit, byte_start, out_started, out_step;
  assign out_step = sck_fall_evt && (phase == PH_DOUT);

  spi_fe_oshift u_oshift (
    .clk(clk), .rst_n(rst_n),
    .clear(cs_fall_evt),
    .step(out_step),
    .next_byte((cmd == CMD_RDSR) ? stat_data : nxt),
    .so_bit(so_bit),
    .byte_start(byte_start),
    .started(out_started)
  );

  assign spi_so_oe = sel_w && !paused && (phase == PH_DOUT) && out_started;
  assign spi_so    = so_bit && spi_so_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      paused <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_s)        paused <= 1'b0;
      else if (!sck_s) paused <= !hold_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      cmd           <= CMD_NONE;
      cnt           <= '0;
      sin           <= '0;
      cur_addr      <= '0;
      byte_seen     <= 1'b0;
      rd_req        <= 1'b0;
      rd_addr       <= '0;
      rd_wait       <= 1'b0;
      nxt           <= '0;
      wren_pulse    <= 1'b0;
      wrdi_pulse    <= 1'b0;
      pg_byte_valid <= 1'b0;
      pg_byte_addr  <= '0;
      pg_byte_data  <= '0;
      pg_commit     <= 1'b0;
      sr_commit     <= 1'b0;
      sr_data       <= '0;
    end else begin
      rd_req        <= 1'b0;
      wren_pulse    <= 1'b0;
      wrdi_pulse    <= 1'b0;
      pg_byte_valid <= 1'b0;
      pg_commit     <= 1'b0;
      sr_commit     <= 1'b0;
      rd_wait       <= rd_req;
      if (rd_wait) nxt <= rd_data;

      if (cs_fall_evt) begin
        phase     <= PH_OPC;
        cmd       <= CMD_NONE;
        cnt       <= '0;
        byte_seen <= 1'b0;
      end else if (cs_rise_evt) begin
        phase <= PH_IDLE;
        cnt   <= '0;
        if (cnt[2:0] == 3'd0 && byte_seen) begin
          if (cmd == CMD_WRITE) pg_commit <= 1'b1;
          if (cmd == CMD_WRSR)  sr_commit <= 1'b1;
        end
      end else if (sck_rise_evt) begin
        sin <= {sin[SW-2:0], si_s};
        if (phase == PH_ADDR) cnt <= cnt + 4'd1;
        else                  cnt <= {1'b0, cnt[2:0] + 3'd1};
        case (phase)
          PH_OPC: if (cnt == 4'd7) begin
            cmd <= cmd_acc;
            case (cmd_acc)
              CMD_WREN:  begin wren_pulse <= 1'b1; phase <= PH_DONE; end
              CMD_WRDI:  begin wrdi_pulse <= 1'b1; phase <= PH_DONE; end
              CMD_RDSR:  phase <= PH_DOUT;
              CMD_WRSR:  phase <= PH_DIN;
              CMD_READ,
              CMD_WRITE: phase <= PH_ADDR;
              default:   phase <= PH_DEAD;
            endcase
          end
          PH_ADDR: if (cnt == 4'd15) begin
            cur_addr <= addr_lo;
            if (cmd == CMD_READ) begin
              rd_req  <= 1'b1;
              rd_addr <= addr_lo;
              phase   <= PH_DOUT;
            end else begin
              phase <= PH_DIN;
            end
          end
          PH_DIN: if (cnt[2:0] == 3'd7) begin
            byte_seen <= 1'b1;
            if (cmd == CMD_WRITE) begin
              pg_byte_valid <= 1'b1;
              pg_byte_addr  <= cur_addr;
              pg_byte_data  <= in_byte;
              cur_addr      <= page_step(cur_addr);
            end else begin
              sr_data <= in_byte;
              phase   <= PH_DONE;
            end
          end
          default: ;
        endcase
      end else if (byte_start && cmd == CMD_READ) begin
        rd_req   <= 1'b1;
        rd_addr  <= read_step(cur_addr);
        cur_addr <= read_step(cur_addr);
      end
    end
  end
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_so_oe,
  input logic       sel_w,
  input logic       paused,
  input logic       dead_w,
  input logic       busy,
  input logic       opc_evt,
  input logic [7:0] in_byte,
  input logic       cs_rise_evt,
  input logic       rd_req,
  input logic       wren_pulse,
  input logic       wrdi_pulse,
  input logic       pg_byte_valid,
  input logic       pg_commit,
  input logic       sr_commit
);
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_w |-> !spi_so_oe); // R11

  AST_PAUSE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !spi_so_oe); // R10

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dead_w |-> (!spi_so_oe && !rd_req && !pg_byte_valid && !wren_pulse && !wrdi_pulse)); // R3

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && opc_evt && !(in_byte[7:4] == 4'h0 && in_byte[2:0] == 3'b101))
      |=> (!wren_pulse && !wrdi_pulse)); // R9

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_pulse, wrdi_pulse, rd_req, pg_byte_valid, pg_commit, sr_commit})); // R2

  AST_COMMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_commit || sr_commit) |-> $past(cs_rise_evt)); // R7
endmodule

bind eeprom_spi_frontend spi_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_so_oe(spi_so_oe), .sel_w(sel_w),
  .paused(paused), .dead_w(dead_w), .busy(busy), .opc_evt(opc_evt),
  .in_byte(in_byte), .cs_rise_evt(cs_rise_evt), .rd_req(rd_req),
  .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse),
  .pg_byte_valid(pg_byte_valid), .pg_commit(pg_commit), .sr_commit(sr_commit)
);

// File: tb/eeprom_spi_frontend_test.sv
`timescale 1ns/1ps
module eeprom_spi_frontend_test;
  localparam int AW = 10;
  localparam int PB = 5;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic spi_so, spi_so_oe;
  logic busy = 1'b0;
  logic [7:0] stat_data = 8'h00;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic wren_pulse, wrdi_pulse, pg_byte_valid, pg_commit, sr_commit;
  logic [AW-1:0] pg_byte_addr;
  logic [7:0] pg_byte_data, sr_data;

  always #2 clk = ~clk;

  eeprom_spi_frontend #(.AW(AW), .PB(PB)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
    .spi_so_oe(spi_so_oe), .busy(busy), .stat_data(stat_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse),
    .pg_byte_valid(pg_byte_valid), .pg_byte_addr(pg_byte_addr),
    .pg_byte_data(pg_byte_data), .pg_commit(pg_commit),
    .sr_commit(sr_commit), .sr_data(sr_data)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  bit m3 = 0;

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return (a[7:0] * 8'd37) ^ {6'b0, a[9:8]} ^ 8'h5A;
  endfunction

  function automatic logic [AW-1:0] page_addr(input logic [AW-1:0] base, input int k);
    logic [PB-1:0] lo;
    lo = base[PB-1:0] + PB'(k);
    return {base[AW-1:PB], lo};
  endfunction

  // Array model and pulse monitors.
  int n_wren = 0, n_wrdi = 0, n_pgc = 0, n_src = 0, n_pg = 0, n_rd = 0;
  logic [AW-1:0] lg_a [0:63];
  logic [7:0]    lg_d [0:63];
  always @(posedge clk) begin
    if (rd_req) begin rd_data <= mem_f(rd_addr); n_rd <= n_rd + 1; end
    if (wren_pulse) n_wren <= n_wren + 1;
    if (wrdi_pulse) n_wrdi <= n_wrdi + 1;
    if (pg_commit)  n_pgc  <= n_pgc + 1;
    if (sr_commit)  n_src  <= n_src + 1;
    if (pg_byte_valid) begin
      lg_a[n_pg % 64] <= pg_byte_addr;
      lg_d[n_pg % 64] <= pg_byte_data;
      n_pg <= n_pg + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic sov, output logic oev);
    spi_sck = 1'b0; spi_si = b;
    wt(HALF);
    sov = spi_so; oev = spi_so_oe;
    spi_sck = 1'b1;
    wt(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic anyoe, output logic alloe);
    logic s, o;
    anyoe = 1'b0; alloe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], s, o);
      rx[i] = s; anyoe |= o; alloe &= o;
    end
  endtask

  task automatic sel_on();
    spi_sck = m3; wt(HALF);
    spi_cs_n = 1'b0; wt(HALF);
  endtask

  task automatic sel_off();
    spi_sck = m3; wt(HALF);
    spi_cs_n = 1'b1; wt(3 * HALF);
  endtask

  task automatic do_read(input logic [15:0] a16, input int n, input string tag);
    logic [7:0] rx; logic ao, al;
    sel_on();
    xbyte(8'h03 | 8'($urandom_range(0, 1) << 3), rx, ao, al);
    chk({tag, " R5 no drive in command"}, ao, 0);
    xbyte(a16[15:8], rx, ao, al);
    xbyte(a16[7:0], rx, ao, al);
    for (int k = 0; k < n; k++) begin
      xbyte(8'($urandom), rx, ao, al);
      chk({tag, " R5 read byte"}, {al, rx}, {1'b1, mem_f(a16[AW-1:0] + AW'(k))});
    end
    sel_off();
  endtask

  task automatic do_write(input logic [15:0] a16, input int n, input string tag);
    logic [7:0] rx, d [0:39]; logic ao, al; int base, c0;
    base = n_pg; c0 = n_pgc;
    sel_on();
    xbyte(8'h02 | 8'($urandom_range(0, 1) << 3), rx, ao, al);
    xbyte(a16[15:8], rx, ao, al);
    xbyte(a16[7:0], rx, ao, al);
    for (int k = 0; k < n; k++) begin
      d[k] = 8'($urandom);
      xbyte(d[k], rx, ao, al);
    end
    sel_off();
    chk({tag, " R6 byte count"}, n_pg - base, n);
    for (int k = 0; k < n; k++) begin
      chk({tag, " R6 page addr"}, lg_a[(base + k) % 64], page_addr(a16[AW-1:0], k));
      chk({tag, " R6 page data"}, lg_d[(base + k) % 64], d[k]);
    end
    chk({tag, " R7 commit"}, n_pgc - c0, 1);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    logic [7:0] rx; logic ao, al;
    sel_on(); xbyte(op, rx, ao, al); sel_off();
  endtask

  initial begin
    int c0, c1, p0;
    logic [7:0] rx; logic ao, al, s, o;
    void'($urandom(32'h1234_5678));
    wt(5); rst_n = 1'b1; wt(5);

    // R1 reset state
    chk("R1 oe after reset", spi_so_oe, 0);
    chk("R1 no pulses", n_wren + n_wrdi + n_pgc + n_src + n_pg + n_rd, 0);

    // R2 / R12 enable and disable with both bit-3 values and both idle levels
    m3 = 0; one_cmd(8'h06); chk("R2 enable 06 idle-low", n_wren, 1);
    m3 = 1; one_cmd(8'h0E); chk("R12 enable 0E idle-high", n_wren, 2);
    m3 = 0; one_cmd(8'h0C); chk("R2 disable 0C", n_wrdi, 1);
    m3 = 1; one_cmd(8'h04); chk("R12 disable 04 idle-high", n_wrdi, 2);

    // R3 invalid command locks out the rest of the select period
    m3 = 0; c0 = n_wren;
    sel_on();
    xbyte(8'h16, rx, ao, al);
    xbyte(8'h06, rx, ao, al);
    xbyte(8'h03, rx, ao, al);
    chk("R3 output stays off", ao, 0);
    sel_off();
    chk("R3 no enable after invalid", n_wren - c0, 0);
    // R11 a fresh select period starts again
    one_cmd(8'h06); chk("R11 command after reselect", n_wren - c0, 1);
    // R11 partial command discarded
    sel_on(); for (int i = 0; i < 4; i++) xbit(1'b0, s, o); sel_off();
    c0 = n_wren; one_cmd(8'h06); chk("R11 partial command dropped", n_wren - c0, 1);

    // R4 status read, refreshed per slot
    for (int md = 0; md < 2; md++) begin
      m3 = md[0];
      stat_data = 8'hA5;
      sel_on();
      xbyte(8'h05 | 8'(md << 3), rx, ao, al);
      chk("R4 off during command", ao, 0);
      xbyte(8'h00, rx, ao, al); chk("R4 status byte 1", {al, rx}, {1'b1, 8'hA5});
      stat_data = 8'h3C;
      xbyte(8'h00, rx, ao, al); chk("R4 status byte 2", {al, rx}, {1'b1, 8'h3C});
      sel_off();
      chk("R11 off when deselected", spi_so_oe, 0);
    end

    // R5 directed wrap at the top with junk upper address bits
    m3 = 0; do_read(16'hFFFE, 4, "top-wrap");
    m3 = 1; do_read(16'h2C00, 2, "upper-ignored");

    // R6 / R7 directed page wrap
    m3 = 0; do_write(16'h001E, 4, "page-wrap");
    m3 = 1; do_write(16'hA3F0, 33, "page-roll");

    // R7 misaligned release: byte seen but no commit
    m3 = 0; c0 = n_pgc; p0 = n_pg;
    sel_on();
    xbyte(8'h02, rx, ao, al); xbyte(8'h00, rx, ao, al); xbyte(8'h40, rx, ao, al);
    xbyte(8'h77, rx, ao, al);
    for (int i = 0; i < 3; i++) xbit(1'b1, s, o);
    sel_off();
    chk("R7 byte before abort", n_pg - p0, 1);
    chk("R7 no commit mid byte", n_pgc - c0, 0);

    // R8 status write
    c0 = n_src;
    sel_on(); xbyte(8'h01, rx, ao, al); xbyte(8'h8C, rx, ao, al); sel_off();
    chk("R8 status commit", n_src - c0, 1);
    chk("R8 status data", sr_data, 8'h8C);
    c0 = n_src;
    m3 = 1;
    sel_on(); xbyte(8'h09, rx, ao, al); for (int i = 0; i < 5; i++) xbit(1'b1, s, o); sel_off();
    chk("R8 no commit on short byte", n_src - c0, 0);

    // R9 busy: only status read survives
    busy = 1'b1; m3 = 0;
    c0 = n_wren; c1 = n_rd;
    one_cmd(8'h06);
    chk("R9 enable rejected", n_wren - c0, 0);
    sel_on();
    xbyte(8'h03, rx, ao, al); xbyte(8'h00, rx, ao, al); xbyte(8'h10, rx, ao, al);
    xbyte(8'h00, rx, ao, al);
    sel_off();
    chk("R9 read rejected no fetch", n_rd - c1, 0);
    chk("R9 read rejected no drive", ao, 0);
    stat_data = 8'hFF;
    sel_on(); xbyte(8'h05, rx, ao, al); xbyte(8'h00, rx, ao, al); sel_off();
    chk("R9 status read while busy", {al, rx}, {1'b1, 8'hFF});
    busy = 1'b0;

    // R10 pause in the middle of a read byte, both idle levels
    for (int md = 0; md < 2; md++) begin
      logic [7:0] got; logic hoe;
      m3 = md[0];
      sel_on();
      xbyte(8'h03, rx, ao, al); xbyte(8'h01, rx, ao, al); xbyte(8'h23, rx, ao, al);
      for (int i = 7; i >= 5; i--) begin xbit(1'b0, s, o); got[i] = s; end
      spi_sck = 1'b0; wt(HALF);
      spi_hold_n = 1'b0; wt(HALF);
      hoe = 1'b0;
      for (int t = 0; t < 4; t++) begin
        spi_sck = 1'b1; spi_si = 1'($urandom); wt(HALF); hoe |= spi_so_oe;
        spi_sck = 1'b0; wt(HALF); hoe |= spi_so_oe;
      end
      spi_hold_n = 1'b1; wt(HALF);
      chk("R10 off while paused", hoe, 0);
      for (int i = 4; i >= 0; i--) begin xbit(1'b0, s, o); got[i] = s; end
      chk("R10 byte intact across pause", got, mem_f(10'h123));
      xbyte(8'h00, rx, ao, al);
      chk("R10 next byte after pause", rx, mem_f(10'h124));
      sel_off();
    end

    // Random mix
    for (int it = 0; it < 24; it++) begin
      m3 = 1'($urandom);
      if ($urandom_range(0, 1) == 0)
        do_read(16'($urandom), $urandom_range(1, 5), "rand-read");
      else
        do_write(16'($urandom), $urandom_range(1, 6), "rand-write");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule